// File: doc/BRIEF.md
# Timer and External Interrupt Flag Unit

This block keeps the pending-interrupt state for two timers and one external interrupt line of a small microcontroller. Single-cycle event pulses from timer 1 (overflow, compare A, compare B, input capture), from timer 0 (overflow) and from an already-qualified external pin event are caught in sticky flags. Each flag is paired with an enable bit. A request goes to the CPU only when the flag, its enable and the global interrupt enable are all one.

When more than one source is pending, the request carries the vector number of the winning source. The CPU acknowledges by returning that vector number, which clears the matching flag. Software reaches the registers through an 8-bit port with a 2-bit address and can clear any flag by writing a one to it.

The address map is fixed:

| Address | Register |
|---|---|
| 0 | timer mask |
| 1 | timer flags |
| 2 | external mask |
| 3 | external flags |

Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `timer_irq_unit`

## Requirements
- R1: After reset, all four registers read 0x00 and no request is raised.
- R2: In the timer mask register (address 0), bits 7, 6, 5, 3 and 1 are writable and read back. Bits 4, 2 and 0 read zero and ignore writes. In the external mask register (address 2), only bit 6 is writable and every other bit reads zero.
- R3: An event pulse sets its flag at the next clock edge, and the flag stays set until it is cleared. The flag positions are:
  - timer 1 overflow: timer flags bit 7
  - compare A: timer flags bit 6
  - compare B: timer flags bit 5
  - input capture: timer flags bit 3
  - timer 0 overflow: timer flags bit 1
  - external event: external flags bit 6
- R4: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R5: A request is raised only when the global enable, the source's enable bit and the source's flag are all one. The enable bit sits at the same position as the flag, in the matching mask register.
- R6: The vector numbers are fixed:
  - external event: 1
  - input capture: 3
  - compare A: 4
  - compare B: 5
  - timer 1 overflow: 6
  - timer 0 overflow: 7
- R7: When several sources request at once, the lowest vector number among the enabled pending sources is presented on the vector output.
- R8: An acknowledge carrying vector number V clears only the flag whose vector is V. An acknowledge with a number that no source uses clears nothing.
- R9: An event pulse in the same cycle as a software clear or an acknowledge clear of the same flag wins, and the flag stays one.
- R10: The reserved bits of both flag registers (timer bits 4, 2, 0; external bits other than 6) read zero and ignore writes.
- R11: Flags set even when their enable bit or the global enable is zero. The request appears as soon as the enables are turned on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| ev_t1_ovf_i | input | 1 | Timer 1 overflow (or PWM direction change at zero) pulse |
| ev_t1_cmpa_i | input | 1 | Timer 1 compare A match pulse |
| ev_t1_cmpb_i | input | 1 | Timer 1 compare B match pulse |
| ev_t1_cap_i | input | 1 | Timer 1 input capture pulse |
| ev_t0_ovf_i | input | 1 | Timer 0 overflow pulse |
| ev_ext0_i | input | 1 | Qualified external interrupt event pulse |
| reg_addr_i | input | 2 | Register select (0 timer mask, 1 timer flags, 2 external mask, 3 external flags) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_req_o | output | 1 | Interrupt request valid |
| irq_vec_o | output | 3 | Vector number of the winning request |
| irq_ack_i | input | 1 | CPU acknowledge strobe |
| irq_ack_vec_i | input | 3 | Vector number being acknowledged |

## Verification
The hardest situation to reach is a set and a clear of the same flag landing in one clock cycle. This happens when a pulse collides either with a write-one-to-clear or with an acknowledge. The directed stimulus first sets the flag, then drives the event pulse together with the write strobe, and separately together with the acknowledge, all within one low clock phase. It then reads the flag register back. The priority order is walked by setting every source at once and acknowledging the presented vector repeatedly, so each step exposes the next-lowest pending source.

// File: rtl/tiu_pkg.sv
package tiu_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int VEC_W   = 3;
  localparam int NUM_SRC = 6;
  localparam int POS_W   = $clog2(DATA_W);
  localparam int IDX_W   = $clog2(NUM_SRC);

  typedef enum logic [ADDR_W-1:0] {
    A_TMASK = 2'd0,
    A_TFLAG = 2'd1,
    A_XMASK = 2'd2,
    A_XFLAG = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic [POS_W-1:0] pos;
    logic             ext;
  } src_info_t;

  // Source index order equals ascending vector order (index 0 wins).
  function automatic src_info_t src_info(input int idx);
    src_info_t s;
    s = '0;
    case (idx)
      0: begin s.vec = 3'd1; s.pos = 3'd6; s.ext = 1'b1; end // external event
      1: begin s.vec = 3'd3; s.pos = 3'd3; s.ext = 1'b0; end // input capture
      2: begin s.vec = 3'd4; s.pos = 3'd6; s.ext = 1'b0; end // compare A
      3: begin s.vec = 3'd5; s.pos = 3'd5; s.ext = 1'b0; end // compare B
      4: begin s.vec = 3'd6; s.pos = 3'd7; s.ext = 1'b0; end // timer1 overflow
      5: begin s.vec = 3'd7; s.pos = 3'd1; s.ext = 1'b0; end // timer0 overflow
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] valid_bits(input logic ext);
    logic [DATA_W-1:0] m;
    src_info_t s;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      s = src_info(i);
      if (s.ext == ext) m[s.pos] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] TMASK_VALID = valid_bits(1'b0);
  localparam logic [DATA_W-1:0] XMASK_VALID = valid_bits(1'b1);

endpackage

// File: rtl/tiu_rst_sync.sv
module tiu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tiu_mask_reg.sv
module tiu_mask_reg #(
  parameter int               W     = 8,
  parameter logic [W-1:0]     VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] d;

  // Reserved positions never hold state.
  always_comb begin
    d = wdata & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= d;
  end

endmodule

// File: rtl/tiu_flag_cell.sv
module tiu_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic load;
  logic flag_d;

  // Set dominates clear; hold when neither.
  always_comb begin
    load   = set_i | clr_i;
    flag_d = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_o <= 1'b0;
    else if (load) flag_o <= flag_d;
  end

endmodule

// File: rtl/tiu_prio_sel.sv
module tiu_prio_sel #(
  parameter int N     = 6,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    any_o = |pend_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/timer_irq_unit.sv
module timer_irq_unit
  import tiu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie_i,
  input  logic              ev_t1_ovf_i,
  input  logic              ev_t1_cmpa_i,
  input  logic              ev_t1_cmpb_i,
  input  logic              ev_t1_cap_i,
  input  logic              ev_t0_ovf_i,
  input  logic              ev_ext0_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              irq_ack_i,
  input  logic [VEC_W-1:0]  irq_ack_vec_i
);

  logic                rst_sync_n;
  logic [NUM_SRC-1:0]  ev_vec;
  logic [NUM_SRC-1:0]  flag_q;
  logic [NUM_SRC-1:0]  pend;
  logic [DATA_W-1:0]   tmask_q;
  logic [DATA_W-1:0]   xmask_q;
  logic [DATA_W-1:0]   tflag_rd;
  logic [DATA_W-1:0]   xflag_rd;
  logic                win_any;
  logic [IDX_W-1:0]    win_idx;
  logic                tflag_wr;
  logic                xflag_wr;

  tiu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Index order follows ascending vector number.
  assign ev_vec = {ev_t0_ovf_i, ev_t1_ovf_i, ev_t1_cmpb_i,
                   ev_t1_cmpa_i, ev_t1_cap_i, ev_ext0_i};

  assign tflag_wr = reg_wr_i && (reg_addr_i == A_TFLAG);
  assign xflag_wr = reg_wr_i && (reg_addr_i == A_XFLAG);

  tiu_mask_reg #(.W(DATA_W), .VALID(TMASK_VALID)) u_tmask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (reg_wr_i && (reg_addr_i == A_TMASK)),
    .wdata (reg_wdata_i),
    .q     (tmask_q)
  );

  tiu_mask_reg #(.W(DATA_W), .VALID(XMASK_VALID)) u_xmask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (reg_wr_i && (reg_addr_i == A_XMASK)),
    .wdata (reg_wdata_i),
    .q     (xmask_q)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam src_info_t INFO = src_info(g);
    logic sw_clr;
    logic hw_clr;
    logic enable;

    assign sw_clr = (INFO.ext ? xflag_wr : tflag_wr) && reg_wdata_i[INFO.pos];
    assign hw_clr = irq_ack_i && (irq_ack_vec_i == INFO.vec);
    assign enable = INFO.ext ? xmask_q[INFO.pos] : tmask_q[INFO.pos];

    tiu_flag_cell u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_i  (ev_vec[g]),
      .clr_i  (sw_clr | hw_clr),
      .flag_o (flag_q[g])
    );

    assign pend[g] = gie_i & enable & flag_q[g];
  end

  // Flag registers are assembled from the cells; reserved bits have no storage.
  always_comb begin
    src_info_t s;
    tflag_rd = '0;
    xflag_rd = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      s = src_info(i);
      if (s.ext) xflag_rd[s.pos] = flag_q[i];
      else       tflag_rd[s.pos] = flag_q[i];
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_TMASK: reg_rdata_o = tmask_q;
      A_TFLAG: reg_rdata_o = tflag_rd;
      A_XMASK: reg_rdata_o = xmask_q;
      default: reg_rdata_o = xflag_rd;
    endcase
  end

  tiu_prio_sel #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i (pend),
    .any_o  (win_any),
    .idx_o  (win_idx)
  );

  always_comb begin
    src_info_t s;
    s         = src_info(int'(win_idx));
    irq_req_o = win_any;
    irq_vec_o = win_any ? s.vec : '0;
  end

endmodule

// File: rtl/tiu_checker.sv
module tiu_checker
  import tiu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              gie_i,
  input logic [NUM_SRC-1:0] ev_vec,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_req_o,
  input logic [VEC_W-1:0]  irq_vec_o,
  input logic              irq_ack_i,
  input logic [VEC_W-1:0]  irq_ack_vec_i
);

  assert_req_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> gie_i);

  assert_vec_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o != 3'd0 && irq_vec_o != 3'd2));

  assert_mask_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_TMASK) |-> ((reg_rdata_o & ~TMASK_VALID) == '0));

  assert_tflag_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_TFLAG) |-> ((reg_rdata_o & ~TMASK_VALID) == '0));

  assert_xflag_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_XFLAG) |-> ((reg_rdata_o & ~XMASK_VALID) == '0));

  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && flag_q[0] && gie_i && irq_vec_o != 3'd1) |-> (irq_vec_o > 3'd1));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    localparam src_info_t INFO = src_info(g);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_vec[g] |=> flag_q[g]);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && irq_ack_vec_i == INFO.vec && !ev_vec[g]) |=> !flag_q[g]);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !reg_wr_i && !(irq_ack_i && irq_ack_vec_i == INFO.vec))
      |=> flag_q[g]);
  end

endmodule

bind timer_irq_unit tiu_checker u_tiu_checker (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .gie_i         (gie_i),
  .ev_vec        (ev_vec),
  .flag_q        (flag_q),
  .reg_addr_i    (reg_addr_i),
  .reg_wr_i      (reg_wr_i),
  .reg_rdata_o   (reg_rdata_o),
  .irq_req_o     (irq_req_o),
  .irq_vec_o     (irq_vec_o),
  .irq_ack_i     (irq_ack_i),
  .irq_ack_vec_i (irq_ack_vec_i)
);

// File: tb/test_timer_irq_unit.sv
module test_timer_irq_unit;

  logic       clk;
  logic       rst_n;
  logic       gie;
  logic [5:0] ev;   // [0] ext, [1] capture, [2] cmpA, [3] cmpB, [4] t1 ovf, [5] t0 ovf
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic       irq_ack;
  logic [2:0] irq_ack_vec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // 20 time units per period: 50 MHz at 1 ns units.
  initial clk = 1'b0;
  always #10 clk = ~clk;

  timer_irq_unit i_timer_irq_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .gie_i         (gie),
    .ev_t1_ovf_i   (ev[4]),
    .ev_t1_cmpa_i  (ev[2]),
    .ev_t1_cmpb_i  (ev[3]),
    .ev_t1_cap_i   (ev[1]),
    .ev_t0_ovf_i   (ev[5]),
    .ev_ext0_i     (ev[0]),
    .reg_addr_i    (reg_addr),
    .reg_wr_i      (reg_wr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .irq_req_o     (irq_req),
    .irq_vec_o     (irq_vec),
    .irq_ack_i     (irq_ack),
    .irq_ack_vec_i (irq_ack_vec)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic check_rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #2;
    check(req, reg_rdata, exp);
  endtask

  task automatic check_irq(input string req, input logic exp_req, input logic [2:0] exp_vec);
    @(negedge clk);
    #2;
    check(req, {7'd0, irq_req}, {7'd0, exp_req});
    if (exp_req) check(req, {5'd0, irq_vec}, {5'd0, exp_vec});
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic ack(input logic [2:0] v);
    @(negedge clk);
    irq_ack = 1'b1; irq_ack_vec = v;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic clean();
    gie = 1'b0;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'hFF);
  endtask

  task automatic t_reset();
    check_rd("R1", 2'd0, 8'h00);
    check_rd("R1", 2'd1, 8'h00);
    check_rd("R1", 2'd2, 8'h00);
    check_rd("R1", 2'd3, 8'h00);
    gie = 1'b1;
    check_irq("R1", 1'b0, 3'd0);
    gie = 1'b0;
  endtask

  task automatic t_mask_rw();
    wr(2'd0, 8'hFF);  check_rd("R2", 2'd0, 8'hEA);
    wr(2'd0, 8'h15);  check_rd("R2", 2'd0, 8'h00);
    wr(2'd0, 8'h8A);  check_rd("R2", 2'd0, 8'h8A);
    wr(2'd2, 8'hFF);  check_rd("R2", 2'd2, 8'h40);
    wr(2'd2, 8'hBF);  check_rd("R2", 2'd2, 8'h00);
    clean();
  endtask

  task automatic t_flag_set();
    gie = 1'b1;
    pulse(6'h3F);
    check_rd("R3", 2'd1, 8'hEA);
    check_rd("R3", 2'd3, 8'h40);
    check_irq("R11", 1'b0, 3'd0);       // masks off: flags set, no request
    wr(2'd0, 8'h02);                    // enable timer0 overflow only
    check_irq("R11", 1'b1, 3'd7);
    clean();
    pulse(6'h02);                       // capture alone
    check_rd("R3", 2'd1, 8'h08);
    repeat (3) @(negedge clk);
    check_rd("R3", 2'd1, 8'h08);        // still held
    clean();
  endtask

  task automatic t_w1c();
    pulse(6'h3F);
    wr(2'd1, 8'h00);  check_rd("R4", 2'd1, 8'hEA);
    wr(2'd1, 8'h80);  check_rd("R4", 2'd1, 8'h6A);
    wr(2'd1, 8'h15);  check_rd("R10", 2'd1, 8'h6A);
    wr(2'd3, 8'hBF);  check_rd("R10", 2'd3, 8'h40);
    wr(2'd3, 8'h40);  check_rd("R4", 2'd3, 8'h00);
    wr(2'd1, 8'hFF);  check_rd("R4", 2'd1, 8'h00);
  endtask

  task automatic t_gating();
    clean();
    pulse(6'h20);                       // timer0 overflow flag
    wr(2'd0, 8'h02);
    gie = 1'b0;
    check_irq("R5", 1'b0, 3'd0);
    gie = 1'b1;
    check_irq("R5", 1'b1, 3'd7);
    wr(2'd0, 8'hFD);
    check_irq("R5", 1'b0, 3'd0);
    clean();
  endtask

  task automatic t_vectors();
    logic [2:0] vecs [6] = '{3'd1, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    logic [7:0] bits [6] = '{8'h40, 8'h08, 8'h40, 8'h20, 8'h80, 8'h02};
    for (int i = 0; i < 6; i++) begin
      clean();
      wr(2'd0, 8'hFF);
      wr(2'd2, 8'hFF);
      gie = 1'b1;
      pulse(6'(1 << i));
      check_irq("R6", 1'b1, vecs[i]);
      check_rd("R3", (i == 0) ? 2'd3 : 2'd1, bits[i]);
    end
    clean();
  endtask

  task automatic t_priority();
    logic [2:0] order [6] = '{3'd1, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'hFF);
    gie = 1'b1;
    pulse(6'h3F);
    ack(3'd2);                          // unused number
    check_rd("R8", 2'd1, 8'hEA);
    check_rd("R8", 2'd3, 8'h40);
    for (int i = 0; i < 6; i++) begin
      check_irq("R7", 1'b1, order[i]);
      ack(order[i]);
    end
    check_irq("R8", 1'b0, 3'd0);
    pulse(6'h3F);
    ack(3'd6);                          // only timer1 overflow
    check_rd("R8", 2'd1, 8'h6A);
    check_rd("R8", 2'd3, 8'h40);
    wr(2'd2, 8'h00);                    // external masked
    check_irq("R7", 1'b1, 3'd3);
    clean();
  endtask

  task automatic t_set_wins();
    pulse(6'h20);
    @(negedge clk);
    ev = 6'h20; reg_addr = 2'd1; reg_wdata = 8'h02; reg_wr = 1'b1;
    @(negedge clk);
    ev = '0; reg_wr = 1'b0;
    check_rd("R9", 2'd1, 8'h02);
    pulse(6'h04);                       // compare A
    @(negedge clk);
    ev = 6'h04; irq_ack = 1'b1; irq_ack_vec = 3'd4;
    @(negedge clk);
    ev = '0; irq_ack = 1'b0;
    check_rd("R9", 2'd1, 8'h42);
    wr(2'd1, 8'h40);
    check_rd("R4", 2'd1, 8'h02);
    clean();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; gie = 1'b0; ev = '0; reg_addr = '0; reg_wr = 1'b0;
    reg_wdata = '0; irq_ack = 1'b0; irq_ack_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mask_rw();
    t_flag_set();
    t_w1c();
    t_gating();
    t_vectors();
    t_priority();
    t_set_wins();
    done = 1'b1;
    summary();
  end

endmodule